// File: doc/BRIEF.md
# Seven-Slot Pixel Lane Serializer

This block turns one 30-bit RGB pixel (ten bits per colour) and four control bits into five serial data lanes and one clock lane, one bit slot at a time. A slot strobe, running at seven times the pixel rate, steps the block through slots 0 to 6. On every strobe all five data lanes and the clock lane are updated together from registers. The whole pixel is shipped across the seven slots, and the clock lane repeats a fixed high/low pattern once per pixel. Differential pads and the generation of the 7x strobe are outside the block.

A static select, `mode_vesa`, picks one of two bit-to-lane layouts. With `mode_vesa = 0` (wide-first layout) the six most significant bits of each colour go on lanes 0 to 2, bits 3:2 on lane 3 and bits 1:0 on lane 4. With `mode_vesa = 1` (low-first layout) the six least significant bits go on lanes 0 to 2, bits 7:6 on lane 3 and bits 9:8 on lane 4. Both layouts put the controls in the same slots. The spare control bit is sent twice, in slot 0 of lanes 3 and 4.

Pixels arrive on a valid/ready stream. `pix_ready` is high for exactly one clock per pixel: the strobe cycle that ends slot 6. A pixel is taken when `pix_valid` and `pix_ready` are both high in that cycle. The block never stalls, so back-pressure is purely rate-based. If `pix_valid` is low at that moment, the block sends an all-zero pixel, controls included, rather than waiting. The mode select is sampled in the same cycle, whether or not a pixel is taken. Upstream must therefore hold its pixel and `pix_valid` until it sees the ready pulse.

Top module: `pixlane_serializer`

## Requirements
- R1: A slot counter starts at 0 after reset. It advances by one on each cycle with `slot_stb` high, goes from 6 back to 0, and holds when `slot_stb` is low.
- R2: `lane_clk` is 1 in slots 0, 1, 5 and 6 and 0 in slots 2, 3 and 4. It is 1 (slot 0) directly after reset.
- R3: `pix_ready` is high only in a cycle where `slot_stb` is high and the slot is 6, and it is high in every such cycle. A pixel is taken when `pix_valid` and `pix_ready` are both high.
- R4: With `mode_vesa` = 0, lanes 0 to 4 (`lane_data[0]` to `lane_data[4]`) carry the following, in slots 0 to 6.
  - Lane 0: G4 R9 R8 R7 R6 R5 R4
  - Lane 1: B5 B4 G9 G8 G7 G6 G5
  - Lane 2: C2 C1 C0 B9 B8 B7 B6
  - Lane 3: C3 B3 B2 G3 G2 R3 R2
  - Lane 4: C3 B1 B0 G1 G0 R1 R0
- R5: With `mode_vesa` = 1, lanes 0 to 4 carry the following, in slots 0 to 6.
  - Lane 0: G0 R5 R4 R3 R2 R1 R0
  - Lane 1: B1 B0 G5 G4 G3 G2 G1
  - Lane 2: C2 C1 C0 B5 B4 B3 B2
  - Lane 3: C3 B7 B6 G7 G6 R7 R6
  - Lane 4: C3 B9 B8 G9 G8 R9 R8
- R6: The control bits are mapped as follows: C0 = `pix_hsync`, C1 = `pix_vsync`, C2 = `pix_de` and C3 = `pix_spare`. In slot 0, lanes 3 and 4 both carry C3.
- R7: The pixel data and `mode_vesa` are sampled only at the slot 6 to slot 0 transition. Changes at other times do not affect the pixel being sent.
- R8: After reset, `lane_data` is 0 until the first pixel has been taken.
- R9: When `pix_valid` is low at the transition, the next seven slots carry 0 on every data lane.
- R10: `lane_data` and `lane_clk` change only in the clock cycle after a cycle with `slot_stb` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_stb | input | 1 | Slot strobe, seven per pixel |
| mode_vesa | input | 1 | Layout select: 0 = wide-first, 1 = low-first |
| pix_valid | input | 1 | Pixel stream valid |
| pix_ready | output | 1 | One-cycle pulse when the pixel is taken |
| pix_red | input | 10 | Red component |
| pix_grn | input | 10 | Green component |
| pix_blu | input | 10 | Blue component |
| pix_hsync | input | 1 | Control bit C0 (horizontal sync) |
| pix_vsync | input | 1 | Control bit C1 (vertical sync) |
| pix_de | input | 1 | Control bit C2 (data enable) |
| pix_spare | input | 1 | Control bit C3 (spare) |
| lane_data | output | 5 | Registered data lane bits, one per lane |
| lane_clk | output | 1 | Registered clock lane bit |

## Verification
A directed sweep of single-bit pixels is sent in both modes. Because each sweep pixel sets only one of the 34 input bits, each one proves that its bit lands on exactly one lane and slot (two for the spare bit) and nowhere else. Random pixels, with random gaps between strobes, test the layouts with dense bit patterns and check that the outputs hold between strobes. Some random pixels have their data and mode scrambled part-way through. Those show that only the values at the boundary count. Dropping `pix_valid` at random boundaries tells a zero pixel apart from a repeat of the last one.

// File: rtl/pixlane_pkg.sv
package pixlane_pkg;
  localparam int SLOTS  = 7;
  localparam int LANES  = 5;
  localparam int CBITS  = 10;
  localparam int CTLB   = 4;
  localparam int HIBITS = 6;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  // bit s = clock lane level in slot s
  localparam logic [SLOTS-1:0] CLK_PAT = 7'b1100011;

  typedef enum logic {
    MAP_WIDE_FIRST = 1'b0,
    MAP_LOW_FIRST  = 1'b1
  } map_mode_e;

  typedef struct packed {
    logic [CTLB-1:0]  ctl;
    logic [CBITS-1:0] r;
    logic [CBITS-1:0] g;
    logic [CBITS-1:0] b;
  } pixel_t;

  // one colour split into the slices that the lanes consume
  typedef struct packed {
    logic [HIBITS-1:0] hi;   // lanes 0..2
    logic [1:0]        f3;   // lane 3
    logic [1:0]        f4;   // lane 4
  } chan_split_t;

  typedef logic [SLOTS-1:0]       lane_word_t;
  typedef lane_word_t [LANES-1:0] lane_frame_t;
endpackage

// File: rtl/pixlane_slot_seq.sv
module pixlane_slot_seq
  import pixlane_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] slot_nxt,
  output logic              boundary,
  output logic              clk_lane_q
);
  assign boundary = stb && (slot_q == LAST_SLOT);
  assign slot_nxt = boundary ? '0 : SLOT_W'(slot_q + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q     <= '0;
      clk_lane_q <= CLK_PAT[0];
    end else if (stb) begin
      slot_q     <= slot_nxt;
      clk_lane_q <= CLK_PAT[slot_nxt];
    end
  end
endmodule

// File: rtl/pixlane_field_sel.sv
module pixlane_field_sel
  import pixlane_pkg::*;
(
  input  pixel_t            pix,
  input  map_mode_e         mode,
  output chan_split_t [2:0] split
);
  logic [2:0][CBITS-1:0] colors;
  assign colors = {pix.b, pix.g, pix.r};   // index 0 = red, 1 = green, 2 = blue

  for (genvar c = 0; c < 3; c++) begin : g_chan
    assign split[c] = (mode == MAP_LOW_FIRST)
      ? '{hi: colors[c][HIBITS-1:0], f3: colors[c][7:6], f4: colors[c][9:8]}
      : '{hi: colors[c][CBITS-1:CBITS-HIBITS], f3: colors[c][3:2], f4: colors[c][1:0]};
  end
endmodule

// File: rtl/pixlane_lane_map.sv
module pixlane_lane_map
  import pixlane_pkg::*;
(
  input  chan_split_t [2:0] split,
  input  logic [CTLB-1:0]   ctl,
  output lane_frame_t       frame
);
  chan_split_t sr, sg, sb;
  assign sr = split[0];
  assign sg = split[1];
  assign sb = split[2];

  // each word listed from slot 6 down to slot 0
  assign frame[0] = {sr.hi[0], sr.hi[1], sr.hi[2], sr.hi[3], sr.hi[4], sr.hi[5], sg.hi[0]};
  assign frame[1] = {sg.hi[1], sg.hi[2], sg.hi[3], sg.hi[4], sg.hi[5], sb.hi[0], sb.hi[1]};
  assign frame[2] = {sb.hi[2], sb.hi[3], sb.hi[4], sb.hi[5], ctl[0], ctl[1], ctl[2]};
  assign frame[3] = {sr.f3[0], sr.f3[1], sg.f3[0], sg.f3[1], sb.f3[0], sb.f3[1], ctl[3]};
  assign frame[4] = {sr.f4[0], sr.f4[1], sg.f4[0], sg.f4[1], sb.f4[0], sb.f4[1], ctl[3]};
endmodule

// File: rtl/pixlane_serializer.sv
module pixlane_serializer
  import pixlane_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_stb,
  input  logic             mode_vesa,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [CBITS-1:0] pix_red,
  input  logic [CBITS-1:0] pix_grn,
  input  logic [CBITS-1:0] pix_blu,
  input  logic             pix_hsync,
  input  logic             pix_vsync,
  input  logic             pix_de,
  input  logic             pix_spare,
  output logic [LANES-1:0] lane_data,
  output logic             lane_clk
);
  logic [SLOT_W-1:0] slot_q, slot_nxt;
  logic              boundary;
  pixel_t            in_pix, cap_pix, sel_pix;
  map_mode_e         cap_mode, sel_mode;
  chan_split_t [2:0] split;
  lane_frame_t       frame;
  logic [LANES-1:0]  lane_q;

  pixlane_slot_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (slot_stb),
    .slot_q     (slot_q),
    .slot_nxt   (slot_nxt),
    .boundary   (boundary),
    .clk_lane_q (lane_clk)
  );

  assign pix_ready = boundary;
  assign in_pix = '{ctl: {pix_spare, pix_de, pix_vsync, pix_hsync},
                    r: pix_red, g: pix_grn, b: pix_blu};

  // at the boundary the incoming pixel feeds slot 0 directly
  always_comb begin
    if (boundary) begin
      sel_pix  = pix_valid ? in_pix : '0;
      sel_mode = map_mode_e'(mode_vesa);
    end else begin
      sel_pix  = cap_pix;
      sel_mode = cap_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_pix  <= '0;
      cap_mode <= MAP_WIDE_FIRST;
    end else if (boundary) begin
      cap_pix  <= sel_pix;
      cap_mode <= sel_mode;
    end
  end

  pixlane_field_sel u_sel (
    .pix   (sel_pix),
    .mode  (sel_mode),
    .split (split)
  );

  pixlane_lane_map u_map (
    .split (split),
    .ctl   (sel_pix.ctl),
    .frame (frame)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
    end else if (slot_stb) begin
      for (int l = 0; l < LANES; l++) lane_q[l] <= frame[l][slot_nxt];
    end
  end

  assign lane_data = lane_q;
endmodule

// File: rtl/pixlane_chk.sv
module pixlane_chk
  import pixlane_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              slot_stb,
  input logic [SLOT_W-1:0] slot,
  input logic              pix_ready,
  input logic [LANES-1:0]  lane_data,
  input logic              lane_clk
);
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= LAST_SLOT);                                                   // R1
  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && slot == LAST_SLOT) |=> (slot == '0));                    // R1
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && slot != LAST_SLOT) |=> (slot == SLOT_W'($past(slot) + 1'b1))); // R1
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_stb |=> $stable(slot));                                         // R1
  AST_CLK_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    lane_clk == CLK_PAT[slot]);                                           // R2
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (slot_stb && slot == LAST_SLOT));                       // R3
  AST_READY_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && slot == LAST_SLOT) |-> pix_ready);                       // R3
  AST_SPARE_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == '0) |-> (lane_data[3] == lane_data[4]));                     // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_stb |=> ($stable(lane_data) && $stable(lane_clk)));             // R10
endmodule

bind pixlane_serializer pixlane_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slot_stb  (slot_stb),
  .slot      (slot_q),
  .pix_ready (pix_ready),
  .lane_data (lane_data),
  .lane_clk  (lane_clk)
);

// File: tb/sim_pixlane_serializer.sv
module sim_pixlane_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slot_stb = 1'b0;
  logic       mode_vesa = 1'b0;
  logic       pix_valid = 1'b0;
  logic [9:0] pix_red = '0, pix_grn = '0, pix_blu = '0;
  logic       pix_hsync = 1'b0, pix_vsync = 1'b0, pix_de = 1'b0, pix_spare = 1'b0;
  wire        pix_ready;
  wire  [4:0] lane_data;
  wire        lane_clk;

  int n_cmp = 0;
  int n_bad = 0;
  int slot_m = 0;
  logic [9:0] mr = '0, mg = '0, mb = '0;
  logic [3:0] mc = '0;
  logic       mm = 1'b0;
  string      tag = "R8";
  bit         finished = 0;
  int unsigned seed_init;

  always #10 clk = ~clk;

  pixlane_serializer u0 (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .mode_vesa(mode_vesa),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_red(pix_red), .pix_grn(pix_grn), .pix_blu(pix_blu),
    .pix_hsync(pix_hsync), .pix_vsync(pix_vsync), .pix_de(pix_de), .pix_spare(pix_spare),
    .lane_data(lane_data), .lane_clk(lane_clk)
  );

  // expected lane word, written from slot 6 down to slot 0; c = {spare, de, vsync, hsync}
  function automatic logic [6:0] exp_lane(logic [9:0] r, logic [9:0] g, logic [9:0] b,
                                          logic [3:0] c, logic vesa, int ln);
    if (!vesa) begin
      case (ln)
        0: return {r[4], r[5], r[6], r[7], r[8], r[9], g[4]};
        1: return {g[5], g[6], g[7], g[8], g[9], b[4], b[5]};
        2: return {b[6], b[7], b[8], b[9], c[0], c[1], c[2]};
        3: return {r[2], r[3], g[2], g[3], b[2], b[3], c[3]};
        default: return {r[0], r[1], g[0], g[1], b[0], b[1], c[3]};
      endcase
    end else begin
      case (ln)
        0: return {r[0], r[1], r[2], r[3], r[4], r[5], g[0]};
        1: return {g[1], g[2], g[3], g[4], g[5], b[0], b[1]};
        2: return {b[2], b[3], b[4], b[5], c[0], c[1], c[2]};
        3: return {r[6], r[7], g[6], g[7], b[6], b[7], c[3]};
        default: return {r[8], r[9], g[8], g[9], b[8], b[9], c[3]};
      endcase
    end
  endfunction

  function automatic logic exp_clk(int s);
    return (s == 0 || s == 1 || s == 5 || s == 6);
  endfunction

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s slot=%0d act=%h exp=%h", what, slot_m, act, exp);
    end
  endtask

  task automatic check_outputs();
    logic [4:0] e;
    for (int ln = 0; ln < 5; ln++) e[ln] = exp_lane(mr, mg, mb, mc, mm, ln)[slot_m];
    chk(lane_data === e, {tag, " lane bits"}, 32'(lane_data), 32'(e));
    chk(lane_clk === exp_clk(slot_m), "R2 clock lane", 32'(lane_clk), 32'(exp_clk(slot_m)));
    if (slot_m == 0)
      chk(lane_data[3] === mc[3] && lane_data[4] === mc[3], "R6 spare duplicated in slot 0",
          32'(lane_data[4:3]), 32'({mc[3], mc[3]}));
  endtask

  task automatic step(int gap);
    logic [4:0] hold_d;
    logic       hold_c;
    @(negedge clk);
    slot_stb = 1'b1;
    #1;
    chk(pix_ready === (slot_m == 6), "R3 ready pulse (R1 slot count)",
        32'(pix_ready), 32'(slot_m == 6));
    if (slot_m == 6) begin
      mm = mode_vesa;
      if (pix_valid) begin
        {mc, mr, mg, mb} = {pix_spare, pix_de, pix_vsync, pix_hsync, pix_red, pix_grn, pix_blu};
        tag = mm ? "R5" : "R4";
      end else begin
        {mc, mr, mg, mb} = '0;
        tag = "R9";
      end
    end
    slot_m = (slot_m == 6) ? 0 : slot_m + 1;
    @(negedge clk);
    slot_stb = 1'b0;
    check_outputs();
    hold_d = lane_data;
    hold_c = lane_clk;
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      chk(lane_data === hold_d && lane_clk === hold_c, "R10 hold between strobes",
          32'({lane_clk, lane_data}), 32'({hold_c, hold_d}));
    end
  endtask

  // call with slot_m == 6; sends one pixel and returns at slot 6 again
  task automatic send_pixel(logic [33:0] v, logic vesa, logic valid, bit scramble);
    @(negedge clk);
    {pix_spare, pix_de, pix_vsync, pix_hsync, pix_red, pix_grn, pix_blu} = v;
    mode_vesa = vesa;
    pix_valid = valid;
    step(int'($urandom % 3));
    for (int k = 1; k < 7; k++) begin
      if (scramble && k == 3) begin
        mode_vesa = ~mode_vesa;
        {pix_red, pix_grn, pix_blu} = {$urandom, $urandom};
        {pix_spare, pix_de, pix_vsync, pix_hsync} = 4'($urandom);
        pix_valid = 1'b1;
        if (tag != "R9") tag = "R7";
      end
      step(int'($urandom % 3));
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    seed_init = $urandom(32'h5EED_0A17);
    repeat (3) @(negedge clk);
    chk(lane_data === 5'b0, "R8 data lanes in reset", 32'(lane_data), 32'h0);
    chk(lane_clk === 1'b1, "R2 clock lane in reset", 32'(lane_clk), 32'h1);
    chk(pix_ready === 1'b0, "R3 ready idle in reset", 32'(pix_ready), 32'h0);
    rst_n = 1'b1;
    // first pixel window: inputs present but not yet taken
    pix_valid = 1'b1;
    pix_red = 10'h3FF; pix_grn = 10'h3FF; pix_blu = 10'h3FF;
    for (int k = 0; k < 6; k++) step(1);
    // single-bit sweep in both modes
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 34; i++)
        send_pixel(34'(1) << i, 1'(m), 1'b1, 1'b0);
    // all ones, then an invalid boundary
    send_pixel({34{1'b1}}, 1'b0, 1'b1, 1'b0);
    send_pixel({34{1'b1}}, 1'b1, 1'b0, 1'b0);
    send_pixel({34{1'b1}}, 1'b1, 1'b1, 1'b1);
    // random traffic
    for (int n = 0; n < 150; n++)
      send_pixel({2'($urandom), $urandom}, 1'($urandom), ($urandom % 5) != 0,
                 ($urandom % 4) == 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule